// File: doc/BRIEF.md
# Dual-Tone Alert Detection Sequencer

This block makes the final decision on whether a dual-tone alerting burst reached the line. Upstream logic supplies a qualify level that goes high when something tone-like is present, a periodicity verdict that rises once the burst has shown the expected envelope structure, and a flag that pulses whenever the gain stage changes its setting. The sequencer times a detection window from the qualify rise. It then checks how long the periodicity verdict stays asserted before the qualify level drops. Only after the burst has ended does it report a valid alert to the host controller, on two active-low status lines.

All timing uses a microsecond tick made inside the block from the system clock by a fractional accumulator, so a clock that is not a whole multiple of 1 MHz still gives the right average rate. Every interval is a parameter in microseconds. A host re-initialise input drops any attempt or report in progress and sends the block back to waiting for a new qualify rise.

Top module: `alert_tone_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, both status outputs (`mode_n_o`, `intb_n_o`) are high and the block is waiting for a qualify rise.
- R2: A low-to-high change on `qual_i` starts a window of `WIN_US` ticks. On the last tick of the window, a high `pre_i` moves the block to the length check. A low `pre_i` ends the attempt and no status pulse follows.
- R3: If `qual_i` goes low before the window completes, the attempt ends and no status pulse follows.
- R4: During the length check, the block counts the ticks on which `pre_i` is high. When `qual_i` falls, the burst is accepted if that count is below `LEN_US`. A count of `LEN_US` or more rejects it.
- R5: A high `gain_chg_i` in any cycle of the window or of the length check ends the attempt on the next clock, with no status pulse.
- R6: After an accepted burst, `mode_n_o` goes low `MODE_DLY_US` ticks after the fall of `qual_i` and stays low for exactly `MODE_W_US` ticks.
- R7: `intb_n_o` goes low `INT_DLY_US` ticks after `mode_n_o` falls and stays low for exactly `INT_W_US` ticks.
- R8: A high `reinit_i` sends the block back to waiting on the next clock. Both outputs are high one clock after that, and whatever was in progress is dropped.
- R9: A `qual_i` rise that happens while status pulses are being output is ignored. It does not start a new window, even after the pulses end, so only one `MODE_W_US`-long `mode_n_o` pulse appears.
- R10: The internal tick fires at an average rate of `TICK_HZ` per `CLK_HZ` clocks, and never on two consecutive clocks when `CLK_HZ` is at least twice `TICK_HZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_i | input | 1 | Qualify level from the seek stage; its rise starts an attempt |
| pre_i | input | 1 | Periodicity verdict from the envelope checker |
| gain_chg_i | input | 1 | Pulses when the gain stage changes setting |
| reinit_i | input | 1 | Host re-initialise request |
| mode_n_o | output | 1 | Active-low alert status, registered |
| intb_n_o | output | 1 | Active-low interrupt request, registered |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that the tick ratio is fixed. They also assume that `reinit_i` takes priority over every other input in the same cycle, so the properties on gain aborts and window entry exclude cycles in which `reinit_i` is high. The stimulus drives every input on the falling clock edge. It holds `qual_i` and `pre_i` at levels for many ticks and gives `gain_chg_i` and `reinit_i` as single-cycle pulses. A bench-side model with a short tick ratio and scaled intervals predicts both outputs on every cycle. Directed scenarios then count the low cycles per burst for accept, reject, abort, re-initialise and re-trigger cases.

// File: rtl/alert_seq_pkg.sv
package alert_seq_pkg;
  typedef enum logic [1:0] {
    ST_SEEK   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_LENGTH = 2'd2,
    ST_REPORT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/alert_us_tick.sv
module alert_us_tick #(
  parameter int CLK_HZ  = 3579545,
  parameter int TICK_HZ = 1000000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ + 1);
  localparam logic [ACC_W-1:0] INC = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] LIM = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  always_comb begin
    sum    = acc_q + INC;
    tick_o = (sum >= LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (tick_o) acc_q <= sum - LIM;
    else acc_q <= sum;
  end

  generate
    if (CLK_HZ >= 2 * TICK_HZ) begin : g_gap_chk
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R10
    end
  endgenerate
endmodule

// File: rtl/alert_edge.sv
module alert_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/alert_seq_core.sv
module alert_seq_core
  import alert_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WIN_US = 58000,
  parameter int LEN_US = 22500,
  parameter int END_US = 18000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             qual_i,
  input  logic             pre_i,
  input  logic             gain_chg_i,
  input  logic             reinit_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_US - 1);
  localparam logic [CNT_W-1:0] END_LAST = CNT_W'(END_US - 1);
  localparam logic [CNT_W-1:0] LEN_LIM  = CNT_W'(LEN_US);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pre_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || reinit_i) begin
      state_q   <= ST_SEEK;
      cnt_q     <= '0;
      pre_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_SEEK: begin
          if (rise_i) begin
            state_q   <= ST_WINDOW;
            cnt_q     <= '0;
            pre_cnt_q <= '0;
          end
        end
        ST_WINDOW: begin
          if (gain_chg_i || !qual_i) begin
            state_q <= ST_SEEK;
            cnt_q   <= '0;
          end else if (tick_i) begin
            if (cnt_q == WIN_LAST) begin
              state_q   <= pre_i ? ST_LENGTH : ST_SEEK;
              cnt_q     <= '0;
              pre_cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_LENGTH: begin
          if (gain_chg_i) begin
            state_q <= ST_SEEK;
            cnt_q   <= '0;
          end else if (!qual_i) begin
            state_q <= (pre_cnt_q < LEN_LIM) ? ST_REPORT : ST_SEEK;
            cnt_q   <= '0;
          end else if (tick_i && pre_i && (pre_cnt_q < LEN_LIM)) begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
          end
        end
        ST_REPORT: begin
          if (tick_i) begin
            if (cnt_q == END_LAST) begin
              state_q <= ST_SEEK;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_SEEK;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  AST_GAIN_ABORT: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WINDOW || state_q == ST_LENGTH) && gain_chg_i && !reinit_i)
      |=> state_q == ST_SEEK); // R5
  AST_REINIT_SEEK: assert property (@(posedge clk) disable iff (rst)
    reinit_i |=> state_q == ST_SEEK); // R8
  AST_WIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WINDOW && $past(state_q) == ST_SEEK) |-> $past(rise_i)); // R2
  AST_PRE_SAT: assert property (@(posedge clk) disable iff (rst)
    pre_cnt_q <= LEN_LIM); // R4
endmodule

// File: rtl/alert_out_gen.sv
module alert_out_gen
  import alert_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MODE_DLY_US = 2000,
  parameter int MODE_W_US   = 18000,
  parameter int INT_DLY_US  = 250,
  parameter int INT_W_US    = 1500
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_state_e       state_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             mode_n_o,
  output logic             intb_n_o
);
  localparam logic [CNT_W-1:0] M_ON  = CNT_W'(MODE_DLY_US);
  localparam logic [CNT_W-1:0] M_OFF = CNT_W'(MODE_DLY_US + MODE_W_US);
  localparam logic [CNT_W-1:0] I_ON  = CNT_W'(MODE_DLY_US + INT_DLY_US);
  localparam logic [CNT_W-1:0] I_OFF = CNT_W'(MODE_DLY_US + INT_DLY_US + INT_W_US);

  logic in_rep;
  assign in_rep = (state_i == ST_REPORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_n_o <= 1'b1;
      intb_n_o <= 1'b1;
    end else begin
      mode_n_o <= !(in_rep && cnt_i >= M_ON && cnt_i < M_OFF);
      intb_n_o <= !(in_rep && cnt_i >= I_ON && cnt_i < I_OFF);
    end
  end

  AST_MODE_ONLY_REPORT: assert property (@(posedge clk) disable iff (rst)
    !mode_n_o |-> $past(state_i) == ST_REPORT); // R6
  AST_INTB_ONLY_REPORT: assert property (@(posedge clk) disable iff (rst)
    !intb_n_o |-> $past(state_i) == ST_REPORT); // R7
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_n_o && intb_n_o)); // R1
endmodule

// File: rtl/alert_tone_seq.sv
module alert_tone_seq
  import alert_seq_pkg::*;
#(
  parameter int CLK_HZ      = 3579545,
  parameter int TICK_HZ     = 1000000,
  parameter int WIN_US      = 58000,
  parameter int LEN_US      = 22500,
  parameter int MODE_DLY_US = 2000,
  parameter int MODE_W_US   = 18000,
  parameter int INT_DLY_US  = 250,
  parameter int INT_W_US    = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  input  logic pre_i,
  input  logic gain_chg_i,
  input  logic reinit_i,
  output logic mode_n_o,
  output logic intb_n_o
);
  localparam int MODE_END = MODE_DLY_US + MODE_W_US;
  localparam int INT_END  = MODE_DLY_US + INT_DLY_US + INT_W_US;
  localparam int END_US   = (MODE_END > INT_END) ? MODE_END : INT_END;
  localparam int MAX_A    = (WIN_US > LEN_US) ? WIN_US : LEN_US;
  localparam int MAX_US   = (MAX_A > END_US) ? MAX_A : END_US;
  localparam int CNT_W    = $clog2(MAX_US + 2);

  logic             tick;
  logic             rise;
  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  alert_us_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  alert_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(qual_i), .rise_o(rise)
  );

  alert_seq_core #(
    .CNT_W(CNT_W), .WIN_US(WIN_US), .LEN_US(LEN_US), .END_US(END_US)
  ) u_core (
    .clk(clk), .rst(rst), .tick_i(tick), .rise_i(rise), .qual_i(qual_i),
    .pre_i(pre_i), .gain_chg_i(gain_chg_i), .reinit_i(reinit_i),
    .state_o(state), .cnt_o(cnt)
  );

  alert_out_gen #(
    .CNT_W(CNT_W), .MODE_DLY_US(MODE_DLY_US), .MODE_W_US(MODE_W_US),
    .INT_DLY_US(INT_DLY_US), .INT_W_US(INT_W_US)
  ) u_out (
    .clk(clk), .rst(rst), .state_i(state), .cnt_i(cnt),
    .mode_n_o(mode_n_o), .intb_n_o(intb_n_o)
  );
endmodule

// File: tb/test_alert_tone_seq.sv
`timescale 1ns/1ps
module test_alert_tone_seq;
  localparam int TDIV = 3;
  localparam int WIN = 40, LEN = 10, MD = 5, MW = 20, ID = 3, IW = 6;
  localparam int ENDT = ((MD + MW) > (MD + ID + IW)) ? (MD + MW) : (MD + ID + IW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic qual = 1'b0, pre = 1'b0, gain = 1'b0, reinit = 1'b0;
  logic mode_n, intb_n;

  always #2 clk = ~clk;

  alert_tone_seq #(
    .CLK_HZ(TDIV), .TICK_HZ(1), .WIN_US(WIN), .LEN_US(LEN),
    .MODE_DLY_US(MD), .MODE_W_US(MW), .INT_DLY_US(ID), .INT_W_US(IW)
  ) i_alert_tone_seq (
    .clk(clk), .rst(rst), .qual_i(qual), .pre_i(pre), .gain_chg_i(gain),
    .reinit_i(reinit), .mode_n_o(mode_n), .intb_n_o(intb_n)
  );

  int checks = 0, errors = 0;
  int mode_lo = 0, int_lo = 0;
  bit done = 0;

  // Behavioural reference: phase 0 wait, 1 window, 2 length, 3 report
  int m_ph, m_phase, m_t, m_pre_t;
  bit m_qprev, m_tick, m_rise;
  bit exp_mode = 1'b1, exp_int = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_phase = 0; m_t = 0; m_pre_t = 0; m_qprev = 0;
      exp_mode = 1; exp_int = 1;
    end else begin
      m_tick = (m_ph == TDIV - 1);
      m_ph = m_tick ? 0 : m_ph + 1;
      m_rise = qual && !m_qprev;
      m_qprev = qual;
      exp_mode = !(m_phase == 3 && m_t >= MD && m_t < MD + MW);
      exp_int  = !(m_phase == 3 && m_t >= MD + ID && m_t < MD + ID + IW);
      if (reinit) begin
        m_phase = 0; m_t = 0; m_pre_t = 0;
      end else if (m_phase == 0) begin
        if (m_rise) begin m_phase = 1; m_t = 0; m_pre_t = 0; end
      end else if (m_phase == 1) begin
        if (gain || !qual) begin m_phase = 0; m_t = 0; end
        else if (m_tick) begin
          m_t++;
          if (m_t == WIN) begin m_phase = pre ? 2 : 0; m_t = 0; m_pre_t = 0; end
        end
      end else if (m_phase == 2) begin
        if (gain) begin m_phase = 0; m_t = 0; end
        else if (!qual) begin m_phase = (m_pre_t < LEN) ? 3 : 0; m_t = 0; end
        else if (m_tick && pre && m_pre_t < LEN) m_pre_t++;
      end else begin
        if (m_tick) begin
          m_t++;
          if (m_t == ENDT) begin m_phase = 0; m_t = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (mode_n !== exp_mode) begin
        errors++;
        $display("FAIL R6 mode_n per-cycle at %0t: actual %b expected %b", $time, mode_n, exp_mode);
      end
      checks++;
      if (intb_n !== exp_int) begin
        errors++;
        $display("FAIL R7 intb_n per-cycle at %0t: actual %b expected %b", $time, intb_n, exp_int);
      end
      if (!mode_n) mode_lo++;
      if (!intb_n) int_lo++;
    end
  end

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clr();
    mode_lo = 0; int_lo = 0;
  endtask

  task automatic pulse_gain();
    gain = 1; clks(1); gain = 0;
  endtask

  // qualify high, pre raised before window end, held len_clks into length check
  task automatic burst(input int len_clks);
    qual = 1; clks(100);
    pre = 1; clks(20 + 5 + len_clks);
    pre = 0; clks(5);
    qual = 0;
  endtask

  initial begin
    clks(4);
    rst = 0;
    @(negedge clk);
    chk("R1 mode_n after reset", mode_n, 1);
    chk("R1 intb_n after reset", intb_n, 1);
    clks(10);

    // R2 R4 R6 R7: accepted burst
    clr(); burst(6); clks(ENDT * TDIV + 20);
    chk("R6 mode low cycles", mode_lo, MW * TDIV);
    chk("R7 intb low cycles", int_lo, IW * TDIV);

    // R2: pre low at window end
    clr(); qual = 1; clks(150); qual = 0; clks(100);
    chk("R2 no report without pre", mode_lo, 0);

    // R4: pre held long in length check -> reject
    clr(); burst(60); clks(100);
    chk("R4 long pre rejected", mode_lo, 0);

    // R4: short pre accepted again
    clr(); burst(3); clks(100);
    chk("R4 short pre accepted", mode_lo, MW * TDIV);

    // R3: qualify drops mid window
    clr(); qual = 1; clks(60); pre = 1; qual = 0; clks(5); pre = 0; clks(100);
    chk("R3 early qual drop", mode_lo, 0);

    // R5: gain change in window
    clr(); qual = 1; clks(60); pulse_gain(); pre = 1; clks(80); pre = 0; qual = 0; clks(100);
    chk("R5 gain abort window", mode_lo, 0);

    // R5: gain change in length check
    clr(); qual = 1; clks(100); pre = 1; clks(27); pulse_gain(); clks(2); pre = 0; qual = 0; clks(100);
    chk("R5 gain abort length", mode_lo, 0);

    // R8: reinit during report
    clr(); burst(3); clks(MD * TDIV + 10);
    reinit = 1; clks(1); reinit = 0; clks(1);
    chk("R8 mode_n high after reinit", mode_n, 1);
    chk("R8 intb_n high after reinit", intb_n, 1);
    clks(100);
    chk("R8 pulse cut short", (mode_lo < MW * TDIV) ? 1 : 0, 1);

    // R9: qualify re-rises during report
    clr(); burst(3); clks(10); qual = 1; clks(250); qual = 0; clks(100);
    chk("R9 single report", mode_lo, MW * TDIV);
    chk("R9 single intb", int_lo, IW * TDIV);

    // R10: tick spacing seen via report length, then idle
    clks(20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule